// File: doc/BRIEF.md
# Display Power and Initialisation Sequencer

This block brings a 128x64 monochrome display module from a fully unpowered state up to a lit screen, and later takes it back down, in an order that protects the panel. It drives the enable for the logic supply, the enable for the panel supply and the module's active-low reset line. It uses a byte-write port (valid/ready, with a flag that marks a byte as pixel data rather than a command) to send a fixed configuration list and a screen-clear burst. A bus or serial writer elsewhere drains that port. Long waits are counted on a millisecond tick input. The short reset-recovery wait is counted in clock cycles.

A mode input picks one of two panel supply schemes: an external panel supply, or a panel supply pumped from inside the module. The mode is captured when power-up is requested and stays fixed for the whole session. Between power-up and power-down the host can also put the panel to sleep and wake it again. A busy output and a one-cycle done pulse report progress.

Top module: `disp_pwr_seq`

## Requirements
- R1: After the synchronous reset `rst`, logic_en, panel_en, disp_rst_n, wr_valid, busy and done are all low.
- R2: A power-up request raises logic_en with disp_rst_n still low. disp_rst_n rises no sooner than STAB_MS ticks later, and the first byte is not transferred until at least RST_CYC clock cycles after disp_rst_n rises.
- R3: In external-supply mode (pump_mode=0) the power-up command bytes are, in order: AE D5 80 A8 3F D3 00 40 8D 10 A1 C8 DA 12 81 9F D9 22 DB 40 A4 A6. Each one is transferred with wr_is_data=0.
- R4: In pumped mode (pump_mode=1) the list is the same except that byte 9 is 14, byte 15 is CF and byte 17 is F1 (counting from 0).
- R5: After the command list, COLS*PAGES (1024) bytes of 00 are sent with wr_is_data=1. panel_en rises only after the last of them.
- R6: After panel_en rises, at least PANEL_MS ticks pass before byte AF is sent as a command. Power-up then ends.
- R7: Power-down from the on state sends AE (pumped mode: AE 8D 10), then drops panel_en, then waits at least PANEL_MS ticks, then drops logic_en and disp_rst_n. logic_en is never low while panel_en is high.
- R8: Sleep from the on state sends AE (pumped mode: AE 8D 10) and drops panel_en. logic_en stays high.
- R9: Wake from sleep sends 8D 14 in pumped mode, raises panel_en, waits at least PANEL_MS ticks, then sends AF.
- R10: While wr_valid is high and wr_ready is low, wr_valid, wr_byte and wr_is_data hold their values. One byte is transferred per cycle in which both are high.
- R11: A request that is not valid in the current state has no effect. This covers any request while busy, power-up or wake in the on state, and so on.
- R12: busy is high from the cycle after an accepted request until the sequence ends. done is high for exactly one cycle at that end, with busy already low.
- R13: The supply mode is sampled at the power-up request. Changing pump_mode later in the session has no effect on sleep, wake or power-down bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pump_mode | input | 1 | 1 = panel supply pumped inside the module, 0 = external supply |
| req_up | input | 1 | Power-up request (accepted when off) |
| req_down | input | 1 | Power-down request (accepted when on or asleep) |
| req_sleep | input | 1 | Sleep request (accepted when on) |
| req_wake | input | 1 | Wake request (accepted when asleep) |
| wr_ready | input | 1 | Byte writer can take a byte |
| logic_en | output | 1 | Logic supply enable |
| panel_en | output | 1 | Panel supply enable |
| disp_rst_n | output | 1 | Active-low reset to the display module |
| wr_valid | output | 1 | Byte on wr_byte is offered |
| wr_byte | output | BYTE_W | Command or data byte |
| wr_is_data | output | 1 | 1 = pixel data, 0 = command |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The sharpest coincidence is a host request that arrives in the same cycle as the final display-on handshake of a power-up. The bench holds the power-down request high for the whole power-up and releases it only in the cycle where done is seen. Any acceptance would appear as an extra AE byte or as panel_en falling, and the bench checks for both. A second overlap, between a stalled byte and the next expected one, is driven by randomly timed wr_ready. It is judged by comparing the full transferred byte log against the list computed in the bench.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_STAB,
    S_RSTW,
    S_SEND,
    S_CLEAR,
    S_PAN_ON,
    S_PANW,
    S_ON,
    S_SLP_PANEL,
    S_SLEEP,
    S_DN_PANEL,
    S_DN_WAIT
  } seq_state_t;

  localparam int ROM_AW = 5;

  // Byte ROM layout: each sequence is a run of consecutive entries
  localparam logic [ROM_AW-1:0] A_CFG_FIRST    = 5'd0;
  localparam logic [ROM_AW-1:0] A_CFG_LAST     = 5'd21;
  localparam logic [ROM_AW-1:0] A_DISP_ON      = 5'd22;
  localparam logic [ROM_AW-1:0] A_DISP_OFF     = 5'd23;
  localparam logic [ROM_AW-1:0] A_PUMP_OFF_END = 5'd25;
  localparam logic [ROM_AW-1:0] A_PUMP_ON      = 5'd26;
  localparam logic [ROM_AW-1:0] A_PUMP_ON_END  = 5'd27;

endpackage

// File: rtl/disp_cmd_rom.sv
module disp_cmd_rom
  import disp_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [ROM_AW-1:0] addr,
  input  logic              pump,
  output logic [BYTE_W-1:0] data
);

  logic [7:0] val;

  always_comb begin
    case (addr)
      5'd0:  val = 8'hAE;
      5'd1:  val = 8'hD5;
      5'd2:  val = 8'h80;
      5'd3:  val = 8'hA8;
      5'd4:  val = 8'h3F;
      5'd5:  val = 8'hD3;
      5'd6:  val = 8'h00;
      5'd7:  val = 8'h40;
      5'd8:  val = 8'h8D;
      5'd9:  val = pump ? 8'h14 : 8'h10;
      5'd10: val = 8'hA1;
      5'd11: val = 8'hC8;
      5'd12: val = 8'hDA;
      5'd13: val = 8'h12;
      5'd14: val = 8'h81;
      5'd15: val = pump ? 8'hCF : 8'h9F;
      5'd16: val = 8'hD9;
      5'd17: val = pump ? 8'hF1 : 8'h22;
      5'd18: val = 8'hDB;
      5'd19: val = 8'h40;
      5'd20: val = 8'hA4;
      5'd21: val = 8'hA6;
      5'd22: val = 8'hAF;   // display on
      5'd23: val = 8'hAE;   // display off
      5'd24: val = 8'h8D;   // pump off pair
      5'd25: val = 8'h10;
      5'd26: val = 8'h8D;   // pump on pair
      5'd27: val = 8'h14;
      default: val = 8'h00;
    endcase
  end

  assign data = BYTE_W'(val);

endmodule

// File: rtl/disp_seq_timer.sv
module disp_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             unit_ms,
  input  logic [CNT_W-1:0] load,
  input  logic             ms_tick,
  output logic             fin
);

  logic             run;
  logic             use_ms;
  logic [CNT_W-1:0] cnt;
  logic             step;

  assign step = run && (!use_ms || ms_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      use_ms <= 1'b0;
      cnt    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        run    <= 1'b1;
        use_ms <= unit_ms;
        cnt    <= load;
      end else if (step) begin
        if (cnt <= CNT_W'(1)) begin
          run <= 1'b0;
          cnt <= '0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  // R6: a started wait is running on the next cycle and expiry is a single pulse
  p_start_runs_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> run);
  p_fin_single_r6: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import disp_seq_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int COLS     = 128,
  parameter int PAGES    = 8,
  parameter int STAB_MS  = 2,
  parameter int PANEL_MS = 100,
  parameter int RST_CYC  = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              pump_mode,
  input  logic              req_up,
  input  logic              req_down,
  input  logic              req_sleep,
  input  logic              req_wake,
  input  logic              wr_ready,
  output logic              logic_en,
  output logic              panel_en,
  output logic              disp_rst_n,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_is_data,
  output logic              busy,
  output logic              done
);

  localparam int CLR_N = COLS * PAGES;
  localparam int CLR_W = (CLR_N > 1) ? $clog2(CLR_N) : 1;
  localparam int T_A   = (STAB_MS > PANEL_MS) ? STAB_MS : PANEL_MS;
  localparam int T_MAX = (T_A > RST_CYC) ? T_A : RST_CYC;
  localparam int TW    = $clog2(T_MAX + 1);

  seq_state_t        state, ret_q;
  logic [ROM_AW-1:0] idx_q, last_q;
  logic              mode_q;
  logic [CLR_W-1:0]  clr_q;
  logic              tmr_start, tmr_ms;
  logic [TW-1:0]     tmr_load;
  logic              fin;
  logic              logic_q, panel_q, rstn_q, valid_q, dat_q, done_q;
  logic [BYTE_W-1:0] rom_byte;
  logic              hs;

  disp_cmd_rom #(.BYTE_W(BYTE_W)) u_rom (
    .addr (idx_q),
    .pump (mode_q),
    .data (rom_byte)
  );

  disp_seq_timer #(.CNT_W(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .unit_ms (tmr_ms),
    .load    (tmr_load),
    .ms_tick (ms_tick),
    .fin     (fin)
  );

  assign hs = valid_q && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_OFF;
      ret_q     <= S_OFF;
      idx_q     <= '0;
      last_q    <= '0;
      mode_q    <= 1'b0;
      clr_q     <= '0;
      tmr_start <= 1'b0;
      tmr_ms    <= 1'b0;
      tmr_load  <= '0;
      logic_q   <= 1'b0;
      panel_q   <= 1'b0;
      rstn_q    <= 1'b0;
      valid_q   <= 1'b0;
      dat_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      tmr_start <= 1'b0;
      done_q    <= 1'b0;
      case (state)
        S_OFF: if (req_up) begin
          logic_q   <= 1'b1;
          mode_q    <= pump_mode;
          tmr_start <= 1'b1;
          tmr_ms    <= 1'b1;
          tmr_load  <= TW'(STAB_MS);
          state     <= S_STAB;
        end
        S_STAB: if (fin) begin
          rstn_q    <= 1'b1;
          tmr_start <= 1'b1;
          tmr_ms    <= 1'b0;
          tmr_load  <= TW'(RST_CYC);
          state     <= S_RSTW;
        end
        S_RSTW: if (fin) begin
          valid_q <= 1'b1;
          dat_q   <= 1'b0;
          idx_q   <= A_CFG_FIRST;
          last_q  <= A_CFG_LAST;
          ret_q   <= S_CLEAR;
          state   <= S_SEND;
        end
        S_SEND: if (hs) begin
          if (idx_q == last_q) begin
            valid_q <= 1'b0;
            state   <= ret_q;
            if (ret_q == S_ON) done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + ROM_AW'(1);
          end
        end
        S_CLEAR: begin
          if (!valid_q) begin
            valid_q <= 1'b1;
            dat_q   <= 1'b1;
            clr_q   <= '0;
          end else if (hs) begin
            if (clr_q == CLR_W'(CLR_N - 1)) begin
              valid_q <= 1'b0;
              dat_q   <= 1'b0;
              state   <= S_PAN_ON;
            end else begin
              clr_q <= clr_q + CLR_W'(1);
            end
          end
        end
        S_PAN_ON: begin
          panel_q   <= 1'b1;
          tmr_start <= 1'b1;
          tmr_ms    <= 1'b1;
          tmr_load  <= TW'(PANEL_MS);
          state     <= S_PANW;
        end
        S_PANW: if (fin) begin
          valid_q <= 1'b1;
          idx_q   <= A_DISP_ON;
          last_q  <= A_DISP_ON;
          ret_q   <= S_ON;
          state   <= S_SEND;
        end
        S_ON: begin
          if (req_down || req_sleep) begin
            valid_q <= 1'b1;
            idx_q   <= A_DISP_OFF;
            last_q  <= mode_q ? A_PUMP_OFF_END : A_DISP_OFF;
            ret_q   <= req_down ? S_DN_PANEL : S_SLP_PANEL;
            state   <= S_SEND;
          end
        end
        S_SLP_PANEL: begin
          panel_q <= 1'b0;
          done_q  <= 1'b1;
          state   <= S_SLEEP;
        end
        S_SLEEP: begin
          if (req_down) begin
            state <= S_DN_PANEL;
          end else if (req_wake) begin
            if (mode_q) begin
              valid_q <= 1'b1;
              idx_q   <= A_PUMP_ON;
              last_q  <= A_PUMP_ON_END;
              ret_q   <= S_PAN_ON;
              state   <= S_SEND;
            end else begin
              state <= S_PAN_ON;
            end
          end
        end
        S_DN_PANEL: begin
          panel_q   <= 1'b0;
          tmr_start <= 1'b1;
          tmr_ms    <= 1'b1;
          tmr_load  <= TW'(PANEL_MS);
          state     <= S_DN_WAIT;
        end
        S_DN_WAIT: if (fin) begin
          logic_q <= 1'b0;
          rstn_q  <= 1'b0;
          done_q  <= 1'b1;
          state   <= S_OFF;
        end
        default: state <= S_OFF;
      endcase
    end
  end

  assign logic_en   = logic_q;
  assign panel_en   = panel_q;
  assign disp_rst_n = rstn_q;
  assign wr_valid   = valid_q;
  assign wr_is_data = dat_q;
  assign wr_byte    = dat_q ? '0 : rom_byte;
  assign busy       = !(state == S_OFF || state == S_ON || state == S_SLEEP);
  assign done       = done_q;

  // R7: panel supply only while logic supply is up
  p_panel_under_logic_r7: assert property (@(posedge clk) disable iff (rst)
    panel_en |-> logic_en);
  // R10: offered byte is frozen while stalled
  p_byte_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_is_data)));
  // R2: no byte while the module is held in reset or unpowered
  p_no_write_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (disp_rst_n && logic_en));
  // R2: the logic supply comes up with reset still asserted
  p_rst_low_at_power_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(logic_en) |-> !disp_rst_n);
  // R12: completion pulse comes with busy already low
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !wr_valid));

endmodule

// File: tb/test_disp_pwr_seq.sv
module test_disp_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int STAB  = 2;
  localparam int PAN   = 100;
  localparam int RCYC  = 20;
  localparam int NCLR  = 1024;
  localparam int NCFG  = 22;
  localparam int LOGN  = 16384;
  localparam int WD_CYC = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic pump_mode = 1'b0;
  logic req_up = 1'b0, req_down = 1'b0, req_sleep = 1'b0, req_wake = 1'b0;
  logic wr_ready = 1'b0;
  logic logic_en, panel_en, disp_rst_n, wr_valid, wr_is_data, busy, done;
  logic [7:0] wr_byte;

  int n_chk = 0;
  int n_bad = 0;

  disp_pwr_seq #(
    .BYTE_W(8), .COLS(128), .PAGES(8),
    .STAB_MS(STAB), .PANEL_MS(PAN), .RST_CYC(RCYC)
  ) i_disp_pwr_seq (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pump_mode(pump_mode),
    .req_up(req_up), .req_down(req_down), .req_sleep(req_sleep), .req_wake(req_wake),
    .wr_ready(wr_ready), .logic_en(logic_en), .panel_en(panel_en),
    .disp_rst_n(disp_rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_is_data(wr_is_data), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick and ready generation, away from the active edge
  int gap = 3;
  always @(negedge clk) begin
    ms_tick = (gap == 0);
    gap = (gap == 0) ? (5 + $urandom_range(0, 2)) : gap - 1;
    wr_ready = ($urandom_range(0, 3) != 0);
  end

  // monitor
  logic [7:0] lg_b [LOGN];
  logic       lg_d [LOGN];
  int         lg_c [LOGN];
  int         lg_t [LOGN];
  int lg_n = 0, cyc = 0, tk = 0;
  int pan_rise_t = 0, pan_rise_c = 0, pan_fall_t = 0;
  int log_rise_t = 0, log_fall_t = 0, rst_rise_t = 0, rst_rise_c = 0;
  int ord_err = 0, hold_err = 0;
  logic pan_p = 0, log_p = 0, rst_p = 0, v_p = 0, r_p = 0, d_p = 0;
  logic [7:0] b_p = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (wr_valid && wr_ready && lg_n < LOGN) begin
        lg_b[lg_n] = wr_byte; lg_d[lg_n] = wr_is_data;
        lg_c[lg_n] = cyc; lg_t[lg_n] = tk; lg_n++;
      end
      if (panel_en && !pan_p) begin pan_rise_t = tk; pan_rise_c = cyc; end
      if (!panel_en && pan_p) pan_fall_t = tk;
      if (logic_en && !log_p) log_rise_t = tk;
      if (!logic_en && log_p) log_fall_t = tk;
      if (disp_rst_n && !rst_p) begin rst_rise_t = tk; rst_rise_c = cyc; end
      if (!logic_en && panel_en) ord_err++;
      if (v_p && !r_p && !(wr_valid && wr_byte == b_p && wr_is_data == d_p)) hold_err++;
      if (ms_tick) tk++;
    end
    pan_p = panel_en; log_p = logic_en; rst_p = disp_rst_n;
    v_p = wr_valid; r_p = wr_ready; b_p = wr_byte; d_p = wr_is_data;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cfg(input int i, input bit p);
    case (i)
      0: return 8'hAE;  1: return 8'hD5;  2: return 8'h80;  3: return 8'hA8;
      4: return 8'h3F;  5: return 8'hD3;  6: return 8'h00;  7: return 8'h40;
      8: return 8'h8D;  9: return p ? 8'h14 : 8'h10;
      10: return 8'hA1; 11: return 8'hC8; 12: return 8'hDA; 13: return 8'h12;
      14: return 8'h81; 15: return p ? 8'hCF : 8'h9F;
      16: return 8'hD9; 17: return p ? 8'hF1 : 8'h22;
      18: return 8'hDB; 19: return 8'h40; 20: return 8'hA4; 21: return 8'hA6;
      default: return 8'hFF;
    endcase
  endfunction

  // which: 0 up, 1 down, 2 sleep, 3 wake. hold keeps req_down high while busy.
  task automatic do_req(input int which, input bit hold, input string r);
    int n;
    bit got;
    bit b1;
    @(negedge clk);
    req_up = (which == 0); req_down = (which == 1);
    req_sleep = (which == 2); req_wake = (which == 3);
    @(negedge clk);
    req_up = 0; req_sleep = 0; req_wake = 0; req_down = hold;
    b1 = busy;
    got = 0; n = 0;
    while (n < 20000 && !got) begin
      if (done) got = 1;
      else begin @(negedge clk); n++; end
    end
    req_down = 0;
    chk(b1 && got, "R12", {30'd0, b1, got}, 3);
    @(negedge clk);
    chk(!done && !busy, "R12", {30'd0, done, busy}, 0);
  endtask

  task automatic expect_cmds(input int s, input int n, input logic [7:0] e0,
                             input logic [7:0] e1, input logic [7:0] e2, input string r);
    logic [7:0] e [3];
    int err;
    e[0] = e0; e[1] = e1; e[2] = e2;
    err = 0;
    if (lg_n - s != n) err++;
    else for (int k = 0; k < n; k++)
      if (lg_b[s+k] != e[k] || lg_d[s+k] != 1'b0) err++;
    chk(err == 0, r, lg_n - s, n);
  endtask

  task automatic check_up(input int s, input bit p);
    int err;
    err = 0;
    chk(lg_n - s == NCFG + NCLR + 1, "R6 count", lg_n - s, NCFG + NCLR + 1);
    if (lg_n - s == NCFG + NCLR + 1) begin
      for (int k = 0; k < NCFG; k++)
        if (lg_b[s+k] != exp_cfg(k, p) || lg_d[s+k]) err++;
      chk(err == 0, p ? "R4 list" : "R3 list", err, 0);
      err = 0;
      for (int k = NCFG; k < NCFG + NCLR; k++)
        if (lg_b[s+k] != 8'h00 || !lg_d[s+k]) err++;
      chk(err == 0, "R5 clear", err, 0);
      chk(pan_rise_c > lg_c[s+NCFG+NCLR-1], "R5 panel after clear",
          pan_rise_c, lg_c[s+NCFG+NCLR-1] + 1);
      chk(lg_b[s+NCFG+NCLR] == 8'hAF && !lg_d[s+NCFG+NCLR], "R6 on byte",
          int'(lg_b[s+NCFG+NCLR]), 'hAF);
      chk(lg_t[s+NCFG+NCLR] - pan_rise_t >= PAN && lg_t[s+NCFG+NCLR] - pan_rise_t <= PAN + 4,
          "R6 wait", lg_t[s+NCFG+NCLR] - pan_rise_t, PAN);
      chk(lg_c[s] - rst_rise_c >= RCYC, "R2 reset gap", lg_c[s] - rst_rise_c, RCYC);
      chk(rst_rise_t - log_rise_t >= STAB, "R2 stab", rst_rise_t - log_rise_t, STAB);
    end
  endtask

  task automatic check_down(input int s, input bit p);
    if (p) expect_cmds(s, 3, 8'hAE, 8'h8D, 8'h10, "R7 bytes");
    else   expect_cmds(s, 1, 8'hAE, 8'h00, 8'h00, "R7 bytes");
    chk(log_fall_t - pan_fall_t >= PAN, "R7 wait", log_fall_t - pan_fall_t, PAN);
    chk(!logic_en && !panel_en && !disp_rst_n, "R7 off",
        {29'd0, logic_en, panel_en, disp_rst_n}, 0);
  endtask

  task automatic check_sleep(input int s, input bit p);
    if (p) expect_cmds(s, 3, 8'hAE, 8'h8D, 8'h10, "R8 bytes");
    else   expect_cmds(s, 1, 8'hAE, 8'h00, 8'h00, "R8 bytes");
    chk(logic_en && !panel_en, "R8 supplies", {30'd0, logic_en, panel_en}, 2);
  endtask

  task automatic check_wake(input int s, input bit p);
    int w;
    if (p) expect_cmds(s, 3, 8'h8D, 8'h14, 8'hAF, "R9 bytes");
    else   expect_cmds(s, 1, 8'hAF, 8'h00, 8'h00, "R9 bytes");
    w = lg_t[lg_n-1] - pan_rise_t;
    chk(panel_en && w >= PAN && w <= PAN + 4, "R9 wait", w, PAN);
  endtask

  task automatic run_all();
    int s;
    bit p;
    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!logic_en && !panel_en && !disp_rst_n && !wr_valid && !busy && !done, "R1 reset",
        {26'd0, logic_en, panel_en, disp_rst_n, wr_valid, busy, done}, 0);

    // R11: requests with no meaning while off are ignored
    @(negedge clk); req_down = 1; req_sleep = 1; req_wake = 1;
    @(negedge clk); req_down = 0; req_sleep = 0; req_wake = 0;
    repeat (10) @(negedge clk);
    chk(!logic_en && !busy && lg_n == 0, "R11 off", lg_n, 0);

    // external session; down held through the whole power-up (R11 in the done cycle)
    pump_mode = 0; s = lg_n;
    do_req(0, 1'b1, "up");
    check_up(s, 1'b0);
    repeat (30) @(negedge clk);
    chk(lg_n == s + NCFG + NCLR + 1 && panel_en && logic_en, "R11 held down", lg_n - s,
        NCFG + NCLR + 1);

    // R11: up and wake while on are ignored
    s = lg_n;
    @(negedge clk); req_up = 1; req_wake = 1;
    @(negedge clk); req_up = 0; req_wake = 0;
    repeat (30) @(negedge clk);
    chk(lg_n == s && !busy && panel_en, "R11 on", lg_n - s, 0);

    s = lg_n; do_req(2, 1'b0, "sleep"); check_sleep(s, 1'b0);
    s = lg_n; do_req(3, 1'b0, "wake");  check_wake(s, 1'b0);
    s = lg_n; do_req(1, 1'b0, "down");  check_down(s, 1'b0);

    // pumped session; mode input flipped after power-up (R13)
    pump_mode = 1; s = lg_n;
    do_req(0, 1'b0, "up");
    check_up(s, 1'b1);
    pump_mode = 0;
    s = lg_n; do_req(2, 1'b0, "sleep"); check_sleep(s, 1'b1);
    chk(lg_n - s == 3, "R13 sleep", lg_n - s, 3);
    s = lg_n; do_req(3, 1'b0, "wake");  check_wake(s, 1'b1);
    chk(lg_n - s == 3, "R13 wake", lg_n - s, 3);
    s = lg_n; do_req(1, 1'b0, "down");  check_down(s, 1'b1);

    // random sessions
    for (int k = 0; k < 2; k++) begin
      p = 1'($urandom_range(0, 1));
      pump_mode = p; s = lg_n;
      do_req(0, 1'b0, "up");
      check_up(s, p);
      pump_mode = ~p;
      s = lg_n; do_req(2, 1'b0, "sleep"); check_sleep(s, p);
      // power-down straight from sleep: no further bytes
      s = lg_n; do_req(1, 1'b0, "down");
      chk(lg_n == s, "R7 from sleep", lg_n - s, 0);
      chk(log_fall_t - pan_fall_t >= PAN && !logic_en, "R7 sleep wait",
          log_fall_t - pan_fall_t, PAN);
    end

    chk(hold_err == 0, "R10 hold", hold_err, 0);
    chk(ord_err == 0, "R7 order", ord_err, 0);
  endtask

  initial begin
    bit wd;
    int seed;
    seed = $urandom(32'd5150);
    wd = 0;
    fork
      run_all();
      begin repeat (WD_CYC) @(posedge clk); wd = 1; end
    join_any
    if (wd) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule